// File: doc/BRIEF.md
# Video Blanking and Vertical Blank Generator

This block builds the single blank-out control that a three-channel video path uses to force its outputs to the blanking level. It takes the raw horizontal and vertical blank pulses, brings both into the local clock domain, and turns the rising edge of the vertical pulse into a vertical blanking interval. That interval lasts a programmable number of scan lines, counted as rising edges of the horizontal pulse.

The output blank is the OR of five sources: the synchronised horizontal blank level, the vertical interval, a software blank bit, the power-save bit and a latched supply-fault flag. A supply-fault strobe sets the flag, and only the power-on reset input clears it. The ordinary reset, register writes and the power-save bit leave it set. The power-save bit is also passed on as a level for the analog stages.

Top module: `vid_blank_gen`

## Requirements
- R1: A rising edge on `vblank_in` starts the vertical interval (`vblank_active` = 1), loaded with `vb_lines` lines. Each later rising edge of `hblank_in` takes away one line, and the interval ends when the count reaches zero. The interval rises on the third clock edge after the input goes high. Each horizontal edge takes effect on the third clock edge after its input goes high.
- R2: A `vb_lines` value of 0, 1 or 2 gives a 3-line interval. Values from 3 to 127 give exactly that many lines.
- R3: While `vb_disable` is 1, no vertical interval starts. Setting it to 1 also ends a running interval at the next clock edge.
- R4: A vertical rising edge that comes during a running interval reloads the full length. If it coincides with a horizontal edge, the reload wins.
- R5: `blank_out` is the OR of these sources: the horizontal blank level, delayed by two clock edges; `vblank_active`; `blank_bit`; `pwr_save_bit`; and `fault_latched`. The register bits act combinationally.
- R6: `pwr_save_out` follows `pwr_save_bit`, and power-save forces `blank_out` to 1.
- R7: A high `fault_strobe` sets `fault_latched` on the third clock edge after it goes high. The flag then stays at 1 through `rst_n`, register changes and further strobes. Only `por` clears it, asynchronously.
- R8: After `rst_n` the synchronisers and the line counter are cleared, so `vblank_active` = 0. `blank_out` then shows only the register bits and the fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the timing logic |
| por | input | 1 | Power-on reset, active high; the only clear of the fault flag |
| hblank_in | input | 1 | Raw horizontal blank pulse |
| vblank_in | input | 1 | Raw vertical blank pulse |
| fault_strobe | input | 1 | Supply-fault detector output |
| vb_lines | input | 7 | Vertical interval length in lines |
| vb_disable | input | 1 | 1 suppresses the vertical interval |
| blank_bit | input | 1 | Software blank request |
| pwr_save_bit | input | 1 | Power-save request |
| blank_out | output | 1 | Composite blank control |
| pwr_save_out | output | 1 | Power-save level |
| vblank_active | output | 1 | Vertical interval in progress |
| fault_latched | output | 1 | Sticky supply-fault flag |

## Verification
The horizontal level reaches `blank_out` two clock edges after the input changes. Vertical starts, line decrements and the fault flag each take effect on the third edge after their input goes high. The register bits and `por` act at once. The bench's reference model keeps a per-edge history of the sampled inputs and applies exactly these delays. The bench drives inputs 2 ns after a rising edge and compares every output at the following falling edge, so each expected value is already settled when it is read.

// File: rtl/vid_blank_gen.sv
module vid_blank_gen #(
  parameter int LEN_W   = 7,
  parameter int MIN_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por,
  input  logic             hblank_in,
  input  logic             vblank_in,
  input  logic             fault_strobe,
  input  logic [LEN_W-1:0] vb_lines,
  input  logic             vb_disable,
  input  logic             blank_bit,
  input  logic             pwr_save_bit,
  output logic             blank_out,
  output logic             pwr_save_out,
  output logic             vblank_active,
  output logic             fault_latched
);

  localparam logic [LEN_W-1:0] LEN_FLOOR = LEN_W'(MIN_LEN);

  logic [2:0]       h_sr, v_sr;
  logic [1:0]       f_sr;
  logic [LEN_W-1:0] lines_left;
  logic             fault_q;

  wire h_rise = h_sr[1] & ~h_sr[2];
  wire v_rise = v_sr[1] & ~v_sr[2];
  wire [LEN_W-1:0] load_len = (vb_lines < LEN_FLOOR) ? LEN_FLOOR : vb_lines;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      h_sr <= '0;
      v_sr <= '0;
      f_sr <= '0;
    end else begin
      h_sr <= {h_sr[1:0], hblank_in};
      v_sr <= {v_sr[1:0], vblank_in};
      f_sr <= {f_sr[0], fault_strobe};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      lines_left <= '0;
    else if (vb_disable)
      lines_left <= '0;
    else if (v_rise)
      lines_left <= load_len;
    else if (h_rise && lines_left != '0)
      lines_left <= lines_left - 1'b1;

  always_ff @(posedge clk or posedge por)
    if (por)
      fault_q <= 1'b0;
    else if (f_sr[1])
      fault_q <= 1'b1;

  assign vblank_active = (lines_left != '0);
  assign fault_latched = fault_q;
  assign pwr_save_out  = pwr_save_bit;
  assign blank_out     = h_sr[1] | vblank_active | blank_bit | pwr_save_bit | fault_q;

  a_r1_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_active && !h_rise && !v_rise && !vb_disable) |=> vblank_active);

  a_r1_ends_on_last_line: assert property (@(posedge clk) disable iff (!rst_n)
    (lines_left == LEN_W'(1) && h_rise && !v_rise && !vb_disable) |=> !vblank_active);

  a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    vb_disable |=> !vblank_active);

  a_r4_restart_full: assert property (@(posedge clk) disable iff (!rst_n)
    (v_rise && !vb_disable) |=> (lines_left >= LEN_FLOOR));

  a_r6_ps_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_save_bit |-> (blank_out && pwr_save_out));

  a_r7_fault_sticky: assert property (@(posedge clk) disable iff (por)
    fault_latched |=> fault_latched);

endmodule

// File: tb/test_vid_blank_gen.sv
module test_vid_blank_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0, por = 1'b1;
  logic hblank_in = 0, vblank_in = 0, fault_strobe = 0;
  logic [6:0] vb_lines = 7'h10;
  logic vb_disable = 1, blank_bit = 0, pwr_save_bit = 0;
  logic blank_out, pwr_save_out, vblank_active, fault_latched;

  always #4 clk = ~clk;

  vid_blank_gen i_vid_blank_gen (
    .clk(clk), .rst_n(rst_n), .por(por), .hblank_in(hblank_in), .vblank_in(vblank_in),
    .fault_strobe(fault_strobe), .vb_lines(vb_lines), .vb_disable(vb_disable),
    .blank_bit(blank_bit), .pwr_save_bit(pwr_save_bit), .blank_out(blank_out),
    .pwr_save_out(pwr_save_out), .vblank_active(vblank_active), .fault_latched(fault_latched));

  int total = 0, failed = 0;
  string tag = "R8";
  bit hq[$] = '{0, 0, 0, 0};
  bit vq[$] = '{0, 0, 0, 0};
  bit fq[$] = '{0, 0, 0, 0};
  int lines = 0;
  bit fault_m = 0;

  always @(posedge clk) begin
    bit hr, vr;
    int ld;
    if (por) fault_m = 0;
    else if (rst_n && fq[1]) fault_m = 1;
    if (!rst_n) begin
      hq = '{0, 0, 0, 0}; vq = '{0, 0, 0, 0}; fq = '{0, 0, 0, 0};
      lines = 0;
    end else begin
      hr = hq[1] && !hq[2];
      vr = vq[1] && !vq[2];
      ld = (vb_lines < 3) ? 3 : int'(vb_lines);
      if (vb_disable) lines = 0;
      else if (vr) lines = ld;
      else if (hr && lines > 0) lines = lines - 1;
      hq.push_front(hblank_in); void'(hq.pop_back());
      vq.push_front(vblank_in); void'(vq.pop_back());
      fq.push_front(fault_strobe); void'(fq.pop_back());
    end
  end

  task automatic check(string req, string what, int got, int exp);
    total++;
    if (got != exp) begin
      failed++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit f_exp, b_exp;
    if (rst_n) begin
      f_exp = por ? 1'b0 : fault_m;
      b_exp = hq[1] | (lines != 0) | blank_bit | pwr_save_bit | f_exp;
      check(tag, "vblank_active", vblank_active, lines != 0);
      check("R5", "blank_out", blank_out, b_exp);
      check("R6", "pwr_save_out", pwr_save_out, pwr_save_bit);
      check("R7", "fault_latched", fault_latched, f_exp);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic hpulse();
    hblank_in = 1; tick(2);
    hblank_in = 0; tick(3);
  endtask

  task automatic vpulse();
    vblank_in = 1; tick(2);
    vblank_in = 0; tick(1);
  endtask

  task automatic run();
    tick(3);
    check("R8", "reset blank_out", blank_out, 0);
    check("R8", "reset vblank_active", vblank_active, 0);
    por = 0; rst_n = 1; tick(3);
    tag = "R3";
    vpulse(); for (int i = 0; i < 4; i++) hpulse();
    check("R3", "disabled no interval", vblank_active, 0);
    tag = "R1";
    vb_disable = 0; vb_lines = 5; tick(1);
    vpulse();
    check("R1", "interval started", vblank_active, 1);
    for (int i = 0; i < 7; i++) hpulse();
    check("R1", "interval ended", vblank_active, 0);
    vb_lines = 127; vpulse();
    for (int i = 0; i < 126; i++) hpulse();
    check("R1", "127 lines not yet over", vblank_active, 1);
    hpulse();
    check("R1", "127 lines over", vblank_active, 0);
    tag = "R2";
    for (int l = 0; l < 4; l++) begin
      vb_lines = 7'(l); vpulse();
      hpulse(); hpulse();
      check("R2", "short length still active", vblank_active, 1);
      hpulse(); hpulse();
    end
    tag = "R4";
    vb_lines = 6; vpulse();
    for (int i = 0; i < 4; i++) hpulse();
    vpulse();
    for (int i = 0; i < 5; i++) hpulse();
    check("R4", "restart reloads", vblank_active, 1);
    hpulse();
    hblank_in = 1; vblank_in = 1; tick(2);
    hblank_in = 0; vblank_in = 0; tick(3);
    for (int i = 0; i < 5; i++) hpulse();
    check("R4", "coincident edge reload", vblank_active, 1);
    tag = "R3";
    vb_disable = 1; tick(1);
    check("R3", "disable ends interval", vblank_active, 0);
    vb_disable = 0; tick(1);
    tag = "R5";
    blank_bit = 1; tick(3); blank_bit = 0; tick(2);
    pwr_save_bit = 1; tick(3);
    check("R6", "power save blanks", blank_out, 1);
    pwr_save_bit = 0; tick(2);
    tag = "R7";
    fault_strobe = 1; tick(1); fault_strobe = 0; tick(3);
    check("R7", "fault set", fault_latched, 1);
    rst_n = 0; tick(2); rst_n = 1; tick(3);
    vb_disable = 1; blank_bit = 1; pwr_save_bit = 1; tick(2);
    blank_bit = 0; pwr_save_bit = 0; tick(2);
    check("R7", "fault survives reset and writes", blank_out, 1);
    por = 1; tick(1); por = 0; tick(2);
    check("R7", "por clears fault", fault_latched, 0);
    check("R7", "blank free after por", blank_out, 0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        total++; failed++;
        $display("FAIL watchdog: got hung expected done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule